// File: doc/BRIEF.md
# DMA Channel Chain Trigger Router

This block links DMA channels into source/destination pairs, so that a destination channel starts by hardware, with no software action, once its paired source channel reaches a chosen completion level. Each channel reports four kinds of completion pulse: fragment, block, transaction and link-list. The block turns the selected kind into a one-cycle start pulse for every destination channel of the same group.

Channels are configured one at a time through a write port that carries a packed 32-bit flags word. The router decodes the role byte and the trigger-level byte of that word. The request-kind byte and the interrupt-kind byte are accepted but have no effect here. Two groups are available, and they run independently of each other. The source channel's trigger level decides which of its completions fires the group. Any destination channel in a group with a firing source gets a start pulse on the next clock.

Top module: `trig_chain_router`

## Requirements
- R1: While `rst_ni` is low, and after it is released, every start output is 0 and every channel acts as role none with trigger level off, so that no completion pulse causes a start until a channel has been configured.
- R2: In a configuration word the role sits in bits 31:24 and the trigger level in bits 23:16. Bits 15:0 (request kind in 15:8, interrupt kind in 7:0) have no effect on any start output.
- R3: Role codes are: 0 none, 1 source of group 0, 2 source of group 1, 3 destination of group 0, 4 destination of group 1.
- R4: Trigger-level codes on a source channel are: 0 off, 1 fragment done, 2 block done, 3 transaction done, 4 link-list done. Only the selected completion input of that channel fires its group.
- R5: A start output goes high exactly one clock after the selected source completion input is sampled high, and stays high for one cycle for each cycle that input is high.
- R6: The two groups are independent: a group-0 source never starts a group-1 destination, and a group-1 source never starts a group-0 destination. Both groups can fire in the same cycle.
- R7: A completion from a source whose group has no destination channel produces no start on any output.
- R8: A channel whose role is none never gets a start pulse, and its completion inputs never cause one.
- R9: Role or trigger-level codes from 5 to 255 behave exactly as code 0.
- R10: A configuration write changes only the addressed channel and takes effect from the next clock. A completion sampled in the same cycle as the write is routed with the previous configuration.
- R11: The trigger level of a destination channel, and the completion inputs of a destination channel, have no effect on any start output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | 2 | Channel index being configured |
| cfg_flags_i | input | 32 | Packed configuration word |
| frag_done_i | input | 4 | Per-channel fragment-done pulse |
| blk_done_i | input | 4 | Per-channel block-done pulse |
| trans_done_i | input | 4 | Per-channel transaction-done pulse |
| list_done_i | input | 4 | Per-channel link-list-done pulse |
| start_trig_o | output | 4 | Per-channel start pulse, registered |

## Verification
The bench targets the following corner cases, and each one would expose a specific fault:
- A write that coincides with a completion pulse. A design that routed through the new configuration would give a wrong start pulse in that cycle.
- Nonzero request and interrupt bytes placed in the word. A design that took its modes from the wrong byte would react to a completion kind it was never set up for.
- Out-of-range role and trigger codes from 5 to 255. A design that masked these codes to three bits would wrongly treat them as valid.
- A destination channel whose own trigger level and completion inputs are active. A design that took the trigger level from the wrong side would fire without a source completion.
- A group whose destination has been removed, and both groups firing in the same cycle. These expose leakage between the groups and phantom starts.

// File: rtl/trig_chain_pkg.sv
`timescale 1ns/1ps
package trig_chain_pkg;
  localparam int FLAG_W  = 32;
  localparam int FIELD_W = 8;
  localparam int ROLE_LSB = 24;
  localparam int TRIG_LSB = 16;
  localparam int NUM_GRP = 2;

  typedef enum logic [2:0] {
    ROLE_NONE = 3'd0,
    ROLE_SRC0 = 3'd1,
    ROLE_SRC1 = 3'd2,
    ROLE_DST0 = 3'd3,
    ROLE_DST1 = 3'd4
  } chain_role_e;

  typedef enum logic [2:0] {
    TRIG_OFF   = 3'd0,
    TRIG_FRAG  = 3'd1,
    TRIG_BLK   = 3'd2,
    TRIG_TRANS = 3'd3,
    TRIG_LIST  = 3'd4
  } trig_sel_e;

  function automatic chain_role_e decode_role(input logic [FIELD_W-1:0] v);
    case (v)
      8'd1:    return ROLE_SRC0;
      8'd2:    return ROLE_SRC1;
      8'd3:    return ROLE_DST0;
      8'd4:    return ROLE_DST1;
      default: return ROLE_NONE;
    endcase
  endfunction

  function automatic trig_sel_e decode_trig(input logic [FIELD_W-1:0] v);
    case (v)
      8'd1:    return TRIG_FRAG;
      8'd2:    return TRIG_BLK;
      8'd3:    return TRIG_TRANS;
      8'd4:    return TRIG_LIST;
      default: return TRIG_OFF;
    endcase
  endfunction
endpackage

// File: rtl/trig_chain_cfg.sv
`timescale 1ns/1ps
module trig_chain_cfg
  import trig_chain_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_we_i,
  input  logic [CH_W-1:0]           cfg_ch_i,
  input  logic [FLAG_W-1:0]         cfg_flags_i,
  output chain_role_e [NUM_CH-1:0]  role_o,
  output trig_sel_e   [NUM_CH-1:0]  trig_o
);
  chain_role_e [NUM_CH-1:0] role_q;
  trig_sel_e   [NUM_CH-1:0] trig_q;

  chain_role_e role_dec;
  trig_sel_e   trig_dec;
  logic        unused_low_fields;

  assign role_dec = decode_role(cfg_flags_i[ROLE_LSB +: FIELD_W]);
  assign trig_dec = decode_trig(cfg_flags_i[TRIG_LSB +: FIELD_W]);
  // request and interrupt bytes carry no routing meaning
  assign unused_low_fields = ^cfg_flags_i[TRIG_LSB-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        role_q[c] <= ROLE_NONE;
        trig_q[c] <= TRIG_OFF;
      end else if (cfg_we_i && (cfg_ch_i == CH_W'(c))) begin
        role_q[c] <= role_dec;
        trig_q[c] <= trig_dec;
      end
    end
  end

  assign role_o = role_q;
  assign trig_o = trig_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> ($stable(role_q) && $stable(trig_q))) else $error("cfg changed without write"); // R10
endmodule

// File: rtl/trig_chain_evsel.sv
`timescale 1ns/1ps
module trig_chain_evsel
  import trig_chain_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  chain_role_e [NUM_CH-1:0]  role_i,
  input  trig_sel_e   [NUM_CH-1:0]  trig_i,
  input  logic [NUM_CH-1:0]         frag_done_i,
  input  logic [NUM_CH-1:0]         blk_done_i,
  input  logic [NUM_CH-1:0]         trans_done_i,
  input  logic [NUM_CH-1:0]         list_done_i,
  output logic [NUM_GRP-1:0]        grp_fire_o
);
  logic [NUM_CH-1:0] src_evt;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    always_comb begin
      case (trig_i[c])
        TRIG_FRAG:  src_evt[c] = frag_done_i[c];
        TRIG_BLK:   src_evt[c] = blk_done_i[c];
        TRIG_TRANS: src_evt[c] = trans_done_i[c];
        TRIG_LIST:  src_evt[c] = list_done_i[c];
        default:    src_evt[c] = 1'b0;
      endcase
    end
  end

  always_comb begin
    grp_fire_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (src_evt[c] && role_i[c] == ROLE_SRC0) grp_fire_o[0] = 1'b1;
      if (src_evt[c] && role_i[c] == ROLE_SRC1) grp_fire_o[1] = 1'b1;
    end
  end

  AST_FIRE_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grp_fire_o) |-> (|(frag_done_i | blk_done_i | trans_done_i | list_done_i))) else $error("fire without completion"); // R4
endmodule

// File: rtl/trig_chain_launch.sv
`timescale 1ns/1ps
module trig_chain_launch
  import trig_chain_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  chain_role_e [NUM_CH-1:0]  role_i,
  input  logic [NUM_GRP-1:0]        fire_i,
  output logic [NUM_CH-1:0]         start_trig_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_dst
    logic hit;
    assign hit = (role_i[c] == ROLE_DST0 && fire_i[0]) ||
                 (role_i[c] == ROLE_DST1 && fire_i[1]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) start_trig_o[c] <= 1'b0;
      else         start_trig_o[c] <= hit;
    end

    AST_DST_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_trig_o[c] |-> $past(role_i[c] == ROLE_DST0 || role_i[c] == ROLE_DST1)) else $error("start on non-destination"); // R8
    AST_PULSE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_trig_o[c] |-> $past(|fire_i)) else $error("start without source fire"); // R5
    AST_GROUP_ISOLATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_trig_o[c] && $past(role_i[c] == ROLE_DST1)) |-> $past(fire_i[1])) else $error("group crossing"); // R6
  end
endmodule

// File: rtl/trig_chain_router.sv
`timescale 1ns/1ps
module trig_chain_router
  import trig_chain_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic [31:0]       cfg_flags_i,
  input  logic [NUM_CH-1:0] frag_done_i,
  input  logic [NUM_CH-1:0] blk_done_i,
  input  logic [NUM_CH-1:0] trans_done_i,
  input  logic [NUM_CH-1:0] list_done_i,
  output logic [NUM_CH-1:0] start_trig_o
);
  chain_role_e [NUM_CH-1:0] role;
  trig_sel_e   [NUM_CH-1:0] trig;
  logic [NUM_GRP-1:0]       grp_fire;

  trig_chain_cfg #(.NUM_CH(NUM_CH)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_ch_i    (cfg_ch_i),
    .cfg_flags_i (cfg_flags_i),
    .role_o      (role),
    .trig_o      (trig)
  );

  trig_chain_evsel #(.NUM_CH(NUM_CH)) u_evsel (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .role_i       (role),
    .trig_i       (trig),
    .frag_done_i  (frag_done_i),
    .blk_done_i   (blk_done_i),
    .trans_done_i (trans_done_i),
    .list_done_i  (list_done_i),
    .grp_fire_o   (grp_fire)
  );

  trig_chain_launch #(.NUM_CH(NUM_CH)) u_launch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .role_i       (role),
    .fire_i       (grp_fire),
    .start_trig_o (start_trig_o)
  );
endmodule

// File: tb/trig_chain_router_test.sv
`timescale 1ns/1ps
module trig_chain_router_test;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_ch = '0;
  logic [31:0] cfg_flags = '0;
  logic [NCH-1:0] frag = '0, blk = '0, trans = '0, lst = '0;
  logic [NCH-1:0] start;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit finished = 0;

  always #2.5 clk = ~clk;

  trig_chain_router uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch),
    .cfg_flags_i(cfg_flags), .frag_done_i(frag), .blk_done_i(blk),
    .trans_done_i(trans), .list_done_i(lst), .start_trig_o(start)
  );

  // behavioural reference
  int m_role[NCH];
  int m_trig[NCH];
  logic [NCH-1:0] m_exp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin m_role[c] = 0; m_trig[c] = 0; end
      m_exp = '0;
    end else begin
      bit f0, f1, ev;
      int r, t;
      f0 = 0; f1 = 0;
      for (int c = 0; c < NCH; c++) begin
        ev = (m_trig[c] == 1 && frag[c]) || (m_trig[c] == 2 && blk[c]) ||
             (m_trig[c] == 3 && trans[c]) || (m_trig[c] == 4 && lst[c]);
        if (ev && m_role[c] == 1) f0 = 1;
        if (ev && m_role[c] == 2) f1 = 1;
      end
      for (int c = 0; c < NCH; c++)
        m_exp[c] = (m_role[c] == 3 && f0) || (m_role[c] == 4 && f1);
      if (cfg_we) begin
        r = int'(cfg_flags[31:24]);
        t = int'(cfg_flags[23:16]);
        m_role[cfg_ch] = (r > 4) ? 0 : r;
        m_trig[cfg_ch] = (t > 4) ? 0 : t;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (start !== m_exp) begin
        fails++;
        $display("FAIL %s model compare: start=%b expected=%b", cur_req, start, m_exp);
      end
    end
  end

  task automatic chk(input logic [NCH-1:0] expv, input string req);
    checks++;
    if (start !== expv) begin
      fails++;
      $display("FAIL %s directed: start=%b expected=%b", req, start, expv);
    end
  endtask

  function automatic logic [31:0] mk(input int r, input int t, input int q, input int i);
    return {8'(r), 8'(t), 8'(q), 8'(i)};
  endfunction

  task automatic wr(input int ch, input logic [31:0] fl);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_flags = fl;
    @(negedge clk);
    cfg_we = 1'b0; cfg_flags = '0;
  endtask

  task automatic pulse(input logic [NCH-1:0] f, b, t, l,
                       input logic [NCH-1:0] expv, input string req);
    cur_req = req;
    frag = f; blk = b; trans = t; lst = l;
    @(negedge clk);
    chk(expv, req);
    frag = '0; blk = '0; trans = '0; lst = '0;
    @(negedge clk);
    chk('0, "R5");
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: start=%b expected=done", start);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk('0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk('0, "R1");
    pulse(4'hF, 4'hF, 4'hF, 4'hF, 4'b0000, "R1");

    // group 0: ch0 source on fragment, ch1 destination
    cur_req = "R3";
    wr(0, mk(1, 1, 0, 0));
    wr(1, mk(3, 0, 0, 0));
    pulse(4'b0001, 0, 0, 0, 4'b0010, "R3");
    pulse(0, 4'b0001, 0, 0, 4'b0000, "R4");
    pulse(4'b0010, 0, 0, 0, 4'b0000, "R11");

    // held completion: two cycles in, two cycles out
    cur_req = "R5";
    frag = 4'b0001;
    @(negedge clk); chk(4'b0010, "R5");
    @(negedge clk); chk(4'b0010, "R5");
    frag = '0;
    @(negedge clk); chk(4'b0000, "R5");

    // request/interrupt bytes set to values that look like modes
    cur_req = "R2";
    wr(0, mk(1, 2, 3, 4));
    pulse(0, 4'b0001, 0, 0, 4'b0010, "R2");
    pulse(4'b0001, 0, 4'b0001, 4'b0001, 4'b0000, "R2");
    wr(0, mk(1, 3, 0, 0));
    pulse(0, 0, 4'b0001, 0, 4'b0010, "R4");
    wr(0, mk(1, 4, 0, 0));
    pulse(0, 0, 0, 4'b0001, 4'b0010, "R4");
    pulse(4'b0001, 4'b0001, 4'b0001, 0, 4'b0000, "R4");

    // group 1: ch2 source on transaction, ch3 destination
    cur_req = "R6";
    wr(2, mk(2, 3, 0, 0));
    wr(3, mk(4, 0, 0, 0));
    pulse(0, 0, 4'b0100, 0, 4'b1000, "R6");
    pulse(0, 0, 0, 4'b0001, 4'b0010, "R6");
    pulse(0, 0, 4'b0100, 4'b0001, 4'b1010, "R6");

    // group 0 without destination
    cur_req = "R7";
    wr(1, mk(0, 0, 0, 0));
    pulse(0, 0, 0, 4'b0001, 4'b0000, "R7");
    pulse(0, 0, 4'b0100, 0, 4'b1000, "R7");

    // out-of-range codes
    cur_req = "R9";
    wr(1, mk(7, 0, 0, 0));
    pulse(0, 0, 0, 4'b0001, 4'b0000, "R9");
    wr(1, mk(3, 0, 0, 0));
    wr(0, mk(1, 200, 0, 0));
    pulse(4'b0001, 4'b0001, 4'b0001, 4'b0001, 4'b0000, "R9");
    wr(0, mk(130, 4, 0, 0));
    pulse(0, 0, 0, 4'b0001, 4'b0000, "R9");
    wr(0, mk(1, 4, 0, 0));
    pulse(0, 0, 0, 4'b0001, 4'b0010, "R9");

    // destination trigger level is irrelevant
    cur_req = "R11";
    wr(1, mk(3, 1, 0, 0));
    pulse(4'b0011, 4'b0010, 4'b0010, 4'b0010, 4'b0000, "R11");
    pulse(0, 0, 0, 4'b0001, 4'b0010, "R11");

    // write coinciding with completion uses old configuration
    cur_req = "R10";
    cfg_we = 1'b1; cfg_ch = 2'd3; cfg_flags = mk(0, 0, 0, 0);
    trans = 4'b0100;
    @(negedge clk);
    chk(4'b1000, "R10");
    cfg_we = 1'b0; cfg_flags = '0; trans = '0;
    @(negedge clk);
    chk(4'b0000, "R10");
    pulse(0, 0, 4'b0100, 0, 4'b0000, "R10");
    pulse(0, 0, 0, 4'b0001, 4'b0010, "R10");

    // role none channel neither produces nor receives
    cur_req = "R8";
    wr(2, mk(0, 3, 0, 0));
    wr(3, mk(4, 0, 0, 0));
    pulse(4'b0100, 4'b0100, 4'b0100, 4'b0100, 4'b0000, "R8");
    wr(0, mk(0, 4, 0, 0));
    pulse(4'b0001, 4'b0001, 4'b0001, 4'b0001, 4'b0000, "R8");

    // reset clears configuration
    cur_req = "R1";
    wr(0, mk(1, 1, 0, 0));
    rst_n = 1'b0;
    @(negedge clk);
    chk('0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    pulse(4'b0001, 0, 0, 0, 4'b0000, "R1");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule